// File: doc/BRIEF.md
# Scalar Double-and-Add Sequencer

This block steers elliptic-curve scalar point multiplication. A scalar key is handed over together with a start pulse. The block first has the base point loaded and the accumulator cleared. It then walks through the key from its top bit down to bit 0. For every bit it commands one point doubling. When the bit is one, a point addition follows. The point arithmetic and the operand storage sit outside the block and are reached only through command strobes.

Every command is a level. It stays high until the unit that serves it answers with its own completion input, so the block's progress is paced by the datapath and not by any fixed cycle count. When the last bit has been served, the block raises a completion flag and keeps it up until the next start. Two counters report how many doublings and additions were commanded in the current run.

Top module: `kp_seq`

## Requirements
- R1: After reset, every command output, `busy_o` and `done_o` are low, and both counters read zero.
- R2: A start in the idle or done state raises `load_x_o` and `clr_z_o` together and holds them until `ack_i` is sampled high. Then `load_y_o` is held until `ack_i` is sampled high.
- R3: The key is captured at start. Bits are served from bit KEY_W-1 down to bit 0, exactly once each.
- R4: Every key bit raises `dbl_start_o`, whatever the bit's value, and holds it until `dbl_done_i` is sampled high.
- R5: When the bit being served is 1, the doubling is followed by `add_start_o`, which is held until `add_done_i` is sampled high. When the bit is 0, the next bit's doubling follows directly.
- R6: At most one of `load_x_o`, `load_y_o`, `dbl_start_o` and `add_start_o` is high in any cycle. The next command appears in the cycle after the clock edge that samples the completion.
- R7: Once the operation for bit 0 completes, `done_o` goes high and `busy_o` goes low. `done_o` stays high until the next start. `busy_o` is high from the cycle after a start until completion.
- R8: A start that arrives while `busy_o` is high is ignored, together with the key presented with it.
- R9: A completion input that does not belong to the command currently high has no effect.
- R10: `dbl_cnt_o` and `add_cnt_o` are cleared on an accepted start. Each rises by one in the cycle its command is raised. At completion they equal KEY_W and the number of ones in the key.
- R11: Pulling `rst_ni` low in the middle of an operation returns the block at once to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle or done |
| key_i | input | KEY_W | Scalar key, sampled with an accepted start |
| ack_i | input | 1 | Completion of a point load or an accumulator clear |
| dbl_done_i | input | 1 | Completion from the doubling unit |
| add_done_i | input | 1 | Completion from the addition unit |
| load_x_o | output | 1 | Command: load base point X |
| clr_z_o | output | 1 | Command: clear the accumulator (issued together with load_x_o) |
| load_y_o | output | 1 | Command: load base point Y |
| dbl_start_o | output | 1 | Command: double the accumulator |
| add_start_o | output | 1 | Command: add the base point to the accumulator |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete, held until the next start |
| dbl_cnt_o | output | CNT_W | Doublings commanded in this run |
| add_cnt_o | output | CNT_W | Additions commanded in this run |

## Verification
A controller that lands in the wrong state shows a wrong command level in the very next cycle, because every strobe is decoded directly from the state register. A key bit that is skipped, read twice, or read in the wrong order shows up later. It appears on the first bit whose value decides between addition and doubling, and in the add counter at that same edge. A wrong bit count moves the completion cycle. Because of this, the bench compares all strobes, flags and counters with an independent operation-queue model on every cycle, not only at completion.

// File: rtl/kp_pkg.sv
package kp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LDX  = 3'd1,
    ST_LDY  = 3'd2,
    ST_DBL  = 3'd3,
    ST_ADD  = 3'd4,
    ST_DONE = 3'd5
  } kp_state_e;

  localparam int unsigned PERF_DBL = 0;
  localparam int unsigned PERF_ADD = 1;
  localparam int unsigned PERF_NUM = 2;

endpackage

// File: rtl/kp_key_reg.sv
module kp_key_reg #(
  parameter int unsigned KEY_W = 261
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             bit_o,
  output logic             last_o
);

  localparam int unsigned IDX_W = $clog2(KEY_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_W - 1);

  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      key_q <= key_i;
      idx_q <= '0;
    end else if (shift_i) begin
      key_q <= {key_q[KEY_W-2:0], 1'b0};
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign bit_o  = key_q[KEY_W-1];
  assign last_o = (idx_q == LAST_IDX);

  // R3
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !load_i |=> idx_q == $past(idx_q) + IDX_W'(1));

  // R3
  bit_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_q == '0);

endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
  import kp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  input  logic dbl_done_i,
  input  logic add_done_i,
  input  logic bit_i,
  input  logic last_i,
  output logic load_key_o,
  output logic shift_o,
  output logic dbl_issue_o,
  output logic add_issue_o,
  output logic cnt_clr_o,
  output logic load_x_o,
  output logic clr_z_o,
  output logic load_y_o,
  output logic dbl_start_o,
  output logic add_start_o,
  output logic busy_o,
  output logic done_o
);

  kp_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    load_key_o  = 1'b0;
    shift_o     = 1'b0;
    dbl_issue_o = 1'b0;
    add_issue_o = 1'b0;
    cnt_clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d    = ST_LDX;
          load_key_o = 1'b1;
          cnt_clr_o  = 1'b1;
        end
      end
      ST_LDX: if (ack_i) state_d = ST_LDY;
      ST_LDY: begin
        if (ack_i) begin
          state_d     = ST_DBL;
          dbl_issue_o = 1'b1;
        end
      end
      ST_DBL: begin
        if (dbl_done_i) begin
          if (bit_i) begin
            state_d     = ST_ADD;
            add_issue_o = 1'b1;
          end else if (last_i) begin
            state_d = ST_DONE;
          end else begin
            state_d     = ST_DBL;
            shift_o     = 1'b1;
            dbl_issue_o = 1'b1;
          end
        end
      end
      ST_ADD: begin
        if (add_done_i) begin
          if (last_i) begin
            state_d = ST_DONE;
          end else begin
            state_d     = ST_DBL;
            shift_o     = 1'b1;
            dbl_issue_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_x_o    = (state_q == ST_LDX);
  assign clr_z_o     = (state_q == ST_LDX);
  assign load_y_o    = (state_q == ST_LDY);
  assign dbl_start_o = (state_q == ST_DBL);
  assign add_start_o = (state_q == ST_ADD);
  assign done_o      = (state_q == ST_DONE);
  assign busy_o      = !(state_q == ST_IDLE || state_q == ST_DONE);

  // R2
  ldx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_x_o && !ack_i |=> load_x_o);

  // R2
  ldy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_y_o && !ack_i |=> load_y_o);

  // R4
  dbl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_start_o && !dbl_done_i |=> dbl_start_o);

  // R5
  add_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_start_o && !add_done_i |=> add_start_o);

  // R5
  one_bit_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_start_o && dbl_done_i && bit_i |=> add_start_o);

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !load_key_o || busy_o);

endmodule

// File: rtl/kp_perf_cnt.sv
module kp_perf_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  // R10
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !inc_i |=> $stable(cnt_o));

  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && inc_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));

endmodule

// File: rtl/kp_seq.sv
module kp_seq
  import kp_pkg::*;
#(
  parameter int unsigned KEY_W = 261,
  parameter int unsigned CNT_W = $clog2(KEY_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             ack_i,
  input  logic             dbl_done_i,
  input  logic             add_done_i,
  output logic             load_x_o,
  output logic             clr_z_o,
  output logic             load_y_o,
  output logic             dbl_start_o,
  output logic             add_start_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] dbl_cnt_o,
  output logic [CNT_W-1:0] add_cnt_o
);

  logic load_key, shift, cur_bit, last_bit, cnt_clr;
  logic dbl_issue, add_issue;
  logic [PERF_NUM-1:0] perf_inc;
  logic [CNT_W-1:0]    perf_cnt [PERF_NUM];

  kp_key_reg #(.KEY_W(KEY_W)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_key),
    .shift_i(shift),
    .key_i  (key_i),
    .bit_o  (cur_bit),
    .last_o (last_bit)
  );

  kp_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ack_i      (ack_i),
    .dbl_done_i (dbl_done_i),
    .add_done_i (add_done_i),
    .bit_i      (cur_bit),
    .last_i     (last_bit),
    .load_key_o (load_key),
    .shift_o    (shift),
    .dbl_issue_o(dbl_issue),
    .add_issue_o(add_issue),
    .cnt_clr_o  (cnt_clr),
    .load_x_o   (load_x_o),
    .clr_z_o    (clr_z_o),
    .load_y_o   (load_y_o),
    .dbl_start_o(dbl_start_o),
    .add_start_o(add_start_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign perf_inc[PERF_DBL] = dbl_issue;
  assign perf_inc[PERF_ADD] = add_issue;

  for (genvar g = 0; g < PERF_NUM; g++) begin : g_perf
    kp_perf_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cnt_clr),
      .inc_i (perf_inc[g]),
      .cnt_o (perf_cnt[g])
    );
  end

  assign dbl_cnt_o = perf_cnt[PERF_DBL];
  assign add_cnt_o = perf_cnt[PERF_ADD];

  // R6
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_x_o, load_y_o, dbl_start_o, add_start_o}));

  // R10
  add_le_dbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_cnt_o <= dbl_cnt_o);

  // R7
  done_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> dbl_cnt_o == CNT_W'(KEY_W));

endmodule

// File: tb/kp_seq_tb.sv
module kp_seq_tb;

  localparam int KW = 261;
  localparam int CW = $clog2(KW + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [KW-1:0] key_i = '0;
  logic ack_i = 1'b0, dbl_done_i = 1'b0, add_done_i = 1'b0;
  logic load_x_o, clr_z_o, load_y_o, dbl_start_o, add_start_o, busy_o, done_o;
  logic [CW-1:0] dbl_cnt_o, add_cnt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model: op codes 0 load X/clear Z, 1 load Y, 2 double, 3 add
  int q[$];
  int done_m = 0, dbl_m = 0, add_m = 0;

  // stub state
  int wait_c = 0, lat = 1;
  bit stray_en = 1'b0;

  always #10ns clk = ~clk;

  kp_seq #(.KEY_W(KW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i),
    .ack_i(ack_i), .dbl_done_i(dbl_done_i), .add_done_i(add_done_i),
    .load_x_o(load_x_o), .clr_z_o(clr_z_o), .load_y_o(load_y_o),
    .dbl_start_o(dbl_start_o), .add_start_o(add_start_o),
    .busy_o(busy_o), .done_o(done_o),
    .dbl_cnt_o(dbl_cnt_o), .add_cnt_o(add_cnt_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      done_m = 0; dbl_m = 0; add_m = 0;
    end else if (q.size() == 0) begin
      if (start_i) begin
        q.push_back(0);
        q.push_back(1);
        for (int i = KW - 1; i >= 0; i--) begin
          q.push_back(2);
          if (key_i[i]) q.push_back(3);
        end
        done_m = 0; dbl_m = 0; add_m = 0;
      end
    end else begin
      bit fire;
      case (q[0])
        0, 1:    fire = ack_i;
        2:       fire = dbl_done_i;
        default: fire = add_done_i;
      endcase
      if (fire) begin
        void'(q.pop_front());
        if (q.size() == 0) done_m = 1;
        else if (q[0] == 2) dbl_m++;
        else if (q[0] == 3) add_m++;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int f;
    f = (q.size() > 0) ? q[0] : -1;
    if (!finished) begin
      chk(rst_ni ? "R2 R3 R4 R5" : "R1",
          {59'd0, load_x_o, clr_z_o, load_y_o, dbl_start_o, add_start_o},
          {59'd0, f == 0, f == 0, f == 1, f == 2, f == 3});
      chk("R6", $onehot0({load_x_o, load_y_o, dbl_start_o, add_start_o}), 1);
      chk("R7", {busy_o, done_o}, {q.size() > 0, done_m != 0});
      chk("R10", {dbl_cnt_o, add_cnt_o}, {CW'(dbl_m), CW'(add_m)});
    end
  end

  // datapath stub
  always @(negedge clk) begin
    if (!rst_ni) begin
      ack_i = 0; dbl_done_i = 0; add_done_i = 0; wait_c = 0;
    end else if (ack_i || dbl_done_i || add_done_i) begin
      ack_i = 0; dbl_done_i = 0; add_done_i = 0; wait_c = 0;
    end else if (load_x_o || load_y_o || dbl_start_o || add_start_o) begin
      if (wait_c >= lat) begin
        ack_i      = load_x_o || load_y_o;
        dbl_done_i = dbl_start_o;
        add_done_i = add_start_o;
        lat = $urandom_range(0, 3);
        wait_c = 0;
      end else begin
        wait_c++;
        // R9: wrong completion pulses
        if (stray_en && $urandom_range(0, 3) == 0) begin
          if (load_x_o || load_y_o) begin dbl_done_i = 1; add_done_i = 1; end
          else if (dbl_start_o)     begin add_done_i = 1; ack_i = 1; end
          else                      begin dbl_done_i = 1; ack_i = 1; end
        end
      end
    end
  end

  task automatic run_key(input logic [KW-1:0] k, input string tag, input bit busy_start);
    @(negedge clk);
    key_i = k; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (busy_start && c == 40) begin
        key_i = ~k; start_i = 1;  // R8: must be ignored
      end else begin
        start_i = 0;
      end
      if (done_o) break;
    end
    chk({tag, " R7 done"}, done_o, 1);
    chk({tag, " R10 doubles"}, dbl_cnt_o, KW);
    chk({tag, " R10 adds"}, add_cnt_o, $countones(k));
    repeat (3) @(negedge clk);
    chk({tag, " R7 done held"}, done_o, 1);
  endtask

  initial begin
    logic [KW-1:0] k;
    repeat (3) @(negedge clk);
    #5ns rst_ni = 1;
    @(negedge clk);
    chk("R1 idle", {busy_o, done_o, dbl_start_o}, 0);

    run_key('0, "R4 zero key", 0);
    run_key('1, "R5 all ones", 0);
    k = '0; for (int i = 0; i < KW; i += 2) k[i] = 1'b1;
    run_key(k, "R5 alternating", 0);
    k = '0; k[KW-1] = 1'b1;
    run_key(k, "R3 msb only", 0);
    k = '0; k[0] = 1'b1;
    run_key(k, "R3 lsb only", 0);
    k = '0;
    while ($countones(k) < 40) k[$urandom_range(0, KW - 1)] = 1'b1;
    run_key(k, "R8 weight 40 busy start", 1);
    stray_en = 1;
    run_key(~k, "R9 stray completions", 0);
    stray_en = 0;

    // R11: reset in mid-operation
    @(negedge clk);
    key_i = '1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (100) @(negedge clk);
    chk("R11 busy before reset", busy_o, 1);
    #5ns rst_ni = 0;
    @(negedge clk);
    chk("R11 idle in reset",
        {busy_o, done_o, load_x_o, load_y_o, dbl_start_o, add_start_o, dbl_cnt_o, add_cnt_o}, 0);
    #5ns rst_ni = 1;
    @(negedge clk);
    chk("R11 idle after reset", {busy_o, done_o}, 0);
    run_key(k, "R11 restart", 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule